// File: doc/BRIEF.md
# Phased Micro-Operation Instruction Sequencer

This block is the control and datapath core of a small accumulator machine. Every instruction is carried out as a series of register transfers among the program counter, the memory address register, the memory buffer register, the instruction register and a single accumulator. A 2-bit phase code selects one of four phases: fetch, indirect, execute or interrupt. Each phase lasts exactly three clock cycles, called time units. The next phase follows fixed rules and is chosen at the end of the third unit.

The block drives one memory port. The address always comes from the memory address register and the write data always comes from the memory buffer register. Read data is combinational: it must be valid within the same cycle in which the read strobe is high. A write takes effect at the clock edge that ends the cycle in which the write strobe is high. The instruction word is 16 bits. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the address field. The opcodes are 001 for accumulate-from-memory (ADD), 111 for HALT, and every other code acts as a no-op.

A pulse on the enable-set input arms interrupts. A request that arrives at the end of an execute phase diverts the machine: it saves the return address at a fixed location and jumps to a fixed handler address.

Top module: `ucyc_seq`

## Requirements
- R1: While rst_n is low and at the first edge after it rises, the state is: phase 00, PC = RESET_PC, accumulator 0, interrupts disarmed, halted_o low, both strobes low.
- R2: phase_o encodes 00 = fetch, 01 = indirect, 10 = execute, 11 = interrupt. Every phase takes exactly three cycles.
- R3: Fetch does three things in order. Unit 0 copies PC into MAR. Unit 1 raises mem_rd with mem_addr equal to PC, loads MBR and adds 1 to PC. Unit 2 copies MBR into IR.
- R4: After fetch, opcode 111 sets halted_o and the phase stays 00. Otherwise, if bit 15 is 1 the next phase is indirect, and if bit 15 is 0 the next phase is execute.
- R5: Indirect reads memory at the IR address field in unit 1. It replaces that field with bits 11:0 of the returned word. Indirect is always followed by execute.
- R6: For opcode 001, execute reads memory at the address field in unit 1. At the end of unit 2 it sets the accumulator to accumulator plus that word, modulo 2^16. Any other opcode leaves the accumulator unchanged and issues no read.
- R7: At the end of execute, the next phase is interrupt if irq_req is high and interrupts are armed. Otherwise the next phase is fetch.
- R8: Interrupt does three things in order. Unit 0 copies PC, zero-extended, into MBR. Unit 1 sets MAR to SAVE_ADDR and PC to ISR_ADDR. Unit 2 raises mem_wr for one cycle, writing the old PC to SAVE_ADDR. Fetch follows.
- R9: A pulse on irq_en_set arms interrupts. Entering the interrupt phase disarms them. A request seen while disarmed has no effect.
- R10: Once halted, the block issues no strobe and PC, accumulator and phase hold still until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory address (MAR) |
| mem_wdata | output | DATA_W | Memory write data (MBR) |
| mem_rdata | input | DATA_W | Memory read data, valid in the strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| irq_req | input | 1 | Interrupt request level |
| irq_en_set | input | 1 | Pulse that arms interrupts |
| phase_o | output | 2 | Current phase code |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| halted_o | output | 1 | High after HALT was fetched |

## Verification
The assertions assume that mem_rdata settles within the read cycle. They also assume that irq_req and irq_en_set change only between clock edges and never at the exact edge that ends an execute phase. The bench meets both assumptions. Its memory answers combinationally from its own array. It drives every input one time step after the rising edge, and it arms interrupts only in a cycle it has chosen, well clear of any phase boundary. The request line is held high from the start, so the phases executed before arming show that a disarmed request is ignored.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    localparam int          OPC_W    = 3;
    localparam logic [2:0]  OPC_NOP  = 3'b000;
    localparam logic [2:0]  OPC_ADD  = 3'b001;
    localparam logic [2:0]  OPC_HALT = 3'b111;

    localparam int UNITS  = 3;
    localparam int UNIT_W = $clog2(UNITS);
endpackage

// File: rtl/ucs_alu.sv
module ucs_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    assign sum_o = a_i + b_i;
endmodule

// File: rtl/ucs_phase_next.sv
module ucs_phase_next
    import ucs_pkg::*;
(
    input  phase_e           phase_i,
    input  logic             ind_flag_i,
    input  logic [OPC_W-1:0] fetched_opc_i,
    input  logic             irq_req_i,
    input  logic             irq_armed_i,
    output phase_e           next_o,
    output logic             halt_o
);
    always_comb begin
        next_o = PH_FETCH;
        halt_o = 1'b0;
        unique case (phase_i)
            PH_FETCH: begin
                if (fetched_opc_i == OPC_HALT) begin
                    halt_o = 1'b1;
                    next_o = PH_FETCH;
                end else if (ind_flag_i) begin
                    next_o = PH_INDIR;
                end else begin
                    next_o = PH_EXEC;
                end
            end
            PH_INDIR: next_o = PH_EXEC;
            PH_EXEC:  next_o = (irq_req_i && irq_armed_i) ? PH_INTR : PH_FETCH;
            PH_INTR:  next_o = PH_FETCH;
            default:  next_o = PH_FETCH;
        endcase
    end
endmodule

// File: rtl/ucyc_seq.sv
module ucyc_seq
    import ucs_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              DATA_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_PC  = '0,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0F0,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h0C0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              irq_req,
    input  logic              irq_en_set,
    output logic [1:0]        phase_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              halted_o
);
    localparam int OPC_LO   = ADDR_W;
    localparam int OPC_HI   = ADDR_W + OPC_W - 1;
    localparam int IND_BIT  = DATA_W - 1;
    localparam int LAST_U   = UNITS - 1;

    typedef struct packed {
        phase_e             phase;
        logic [UNIT_W-1:0]  unit;
        logic [ADDR_W-1:0]  pc;
        logic [ADDR_W-1:0]  mar;
        logic [DATA_W-1:0]  mbr;
        logic [DATA_W-1:0]  ir;
        logic [DATA_W-1:0]  acc;
        logic               armed;
        logic               halted;
    } state_t;

    state_t st_q, st_d;

    logic [DATA_W-1:0] sum_w;
    phase_e            next_phase_w;
    logic              halt_w;
    logic              last_unit_w;
    logic              ir_is_add_w;
    logic [UNIT_W-1:0] unit_w;
    logic              armed_w;

    ucs_alu #(.W(DATA_W)) u_alu (
        .a_i   (st_q.acc),
        .b_i   (st_q.mbr),
        .sum_o (sum_w)
    );

    ucs_phase_next u_next (
        .phase_i       (st_q.phase),
        .ind_flag_i    (st_q.mbr[IND_BIT]),
        .fetched_opc_i (st_q.mbr[OPC_HI:OPC_LO]),
        .irq_req_i     (irq_req),
        .irq_armed_i   (st_q.armed),
        .next_o        (next_phase_w),
        .halt_o        (halt_w)
    );

    assign last_unit_w = (st_q.unit == UNIT_W'(LAST_U));
    assign ir_is_add_w = (st_q.ir[OPC_HI:OPC_LO] == OPC_ADD);

    always_comb begin
        st_d = st_q;
        if (irq_en_set) st_d.armed = 1'b1;
        if (!st_q.halted) begin
            unique case (st_q.phase)
                PH_FETCH: begin
                    case (st_q.unit)
                        UNIT_W'(0): st_d.mar = st_q.pc;
                        UNIT_W'(1): begin
                            st_d.mbr = mem_rdata;
                            st_d.pc  = st_q.pc + 1'b1;
                        end
                        default:    st_d.ir = st_q.mbr;
                    endcase
                end
                PH_INDIR: begin
                    case (st_q.unit)
                        UNIT_W'(0): st_d.mar = st_q.ir[ADDR_W-1:0];
                        UNIT_W'(1): st_d.mbr = mem_rdata;
                        default:    st_d.ir[ADDR_W-1:0] = st_q.mbr[ADDR_W-1:0];
                    endcase
                end
                PH_EXEC: begin
                    case (st_q.unit)
                        UNIT_W'(0): st_d.mar = st_q.ir[ADDR_W-1:0];
                        UNIT_W'(1): if (ir_is_add_w) st_d.mbr = mem_rdata;
                        default:    if (ir_is_add_w) st_d.acc = sum_w;
                    endcase
                end
                PH_INTR: begin
                    case (st_q.unit)
                        UNIT_W'(0): st_d.mbr = DATA_W'(st_q.pc);
                        UNIT_W'(1): begin
                            st_d.mar = SAVE_ADDR;
                            st_d.pc  = ISR_ADDR;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase

            if (last_unit_w) begin
                st_d.unit  = '0;
                st_d.phase = next_phase_w;
                if (halt_w) st_d.halted = 1'b1;
                if (next_phase_w == PH_INTR) st_d.armed = 1'b0;
            end else begin
                st_d.unit = st_q.unit + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_FETCH;
            st_q.pc     <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.mar;
    assign mem_wdata = st_q.mbr;
    assign mem_rd    = !st_q.halted && (st_q.unit == UNIT_W'(1)) &&
                       ((st_q.phase == PH_FETCH) || (st_q.phase == PH_INDIR) ||
                        ((st_q.phase == PH_EXEC) && ir_is_add_w));
    assign mem_wr    = (st_q.phase == PH_INTR) && last_unit_w;

    assign phase_o  = st_q.phase;
    assign pc_o     = st_q.pc;
    assign acc_o    = st_q.acc;
    assign halted_o = st_q.halted;
    assign unit_w   = st_q.unit;
    assign armed_w  = st_q.armed;
endmodule

// File: rtl/ucyc_seq_chk.sv
module ucyc_seq_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 16,
    parameter int                UNIT_W    = 2,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase_i,
    input logic [UNIT_W-1:0] unit_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [DATA_W-1:0] acc_i,
    input logic              halted_i,
    input logic              armed_i,
    input logic              irq_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i
);
    assert_unit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(unit_i) < 3);

    assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b00 && unit_i == UNIT_W'(1) && !halted_i) |-> (rd_i && addr_i == pc_i));

    assert_fetch_pc_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b00 && unit_i == UNIT_W'(1) && !halted_i) |=> (pc_i == $past(pc_i) + 1'b1));

    assert_indir_to_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b01 && unit_i == UNIT_W'(2)) |=> (phase_i == 2'b10));

    assert_irq_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b10 && unit_i == UNIT_W'(2) && irq_i && armed_i) |=> (phase_i == 2'b11 && !armed_i));

    assert_intr_to_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b11 && unit_i == UNIT_W'(2)) |=> (phase_i == 2'b00 && unit_i == '0));

    assert_save_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (addr_i == SAVE_ADDR && !rd_i));

    assert_disarmed_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'b10 && unit_i == UNIT_W'(2) && !armed_i) |=> (phase_i == 2'b00));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |=> (halted_i && $stable(pc_i) && $stable(acc_i) && !rd_i && !wr_i));
endmodule

bind ucyc_seq ucyc_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .UNIT_W    (ucs_pkg::UNIT_W),
    .SAVE_ADDR (SAVE_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase_o),
    .unit_i   (unit_w),
    .pc_i     (pc_o),
    .acc_i    (acc_o),
    .halted_i (halted_o),
    .armed_i  (armed_w),
    .irq_i    (irq_req),
    .rd_i     (mem_rd),
    .wr_i     (mem_wr),
    .addr_i   (mem_addr)
);

// File: tb/test_ucyc_seq.sv
module test_ucyc_seq;
    localparam int          AW   = 12;
    localparam int          DW   = 16;
    localparam logic [11:0] SAVE = 12'h0F0;
    localparam logic [11:0] ISR  = 12'h0C0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_rd, mem_wr;
    logic          irq_req = 1'b0, irq_en_set = 1'b0;
    logic [1:0]    phase_o;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] acc_o;
    logic          halted_o;

    logic [DW-1:0] mem [0:255];
    int checks = 0, fails = 0, writes_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        writes_seen <= writes_seen + 1;
    end

    ucyc_seq #(.ADDR_W(AW), .DATA_W(DW), .RESET_PC(12'h000),
               .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) i_ucyc_seq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .irq_req(irq_req), .irq_en_set(irq_en_set), .phase_o(phase_o),
        .pc_o(pc_o), .acc_o(acc_o), .halted_o(halted_o));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: integers stepped once per cycle
    int m_ph, m_u, m_pc, m_mar, m_mbr, m_ir, m_acc, m_arm, m_halt;

    task automatic model_reset();
        m_ph = 0; m_u = 0; m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0;
        m_acc = 0; m_arm = 0; m_halt = 0;
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        int e_rd, e_wr, opc, nph;
        opc  = (m_ir >> 12) & 7;
        e_rd = (!m_halt && m_u == 1 && (m_ph == 0 || m_ph == 1 || (m_ph == 2 && opc == 1))) ? 1 : 0;
        e_wr = (m_ph == 3 && m_u == 2) ? 1 : 0;
        chk("R2 phase", int'(phase_o), m_ph);
        chk("R3 pc", int'(pc_o), m_pc);
        chk("R6 acc", int'(acc_o), m_acc);
        chk("R10 halted", int'(halted_o), m_halt);
        chk("R3 rd strobe", int'(mem_rd), e_rd);
        chk("R8 wr strobe", int'(mem_wr), e_wr);
        if (e_rd || e_wr) chk("R5 addr", int'(mem_addr), m_mar);
        if (e_wr) chk("R8 wdata", int'(mem_wdata), m_mbr);
        // advance to the state after the next edge
        if (irq_en_set) m_arm = 1;
        if (!m_halt) begin
            nph = m_ph;
            case (m_ph)
                0: if (m_u == 0) m_mar = m_pc;
                   else if (m_u == 1) begin m_mbr = int'(mem[m_mar & 255]); m_pc = (m_pc + 1) & 12'hFFF; end
                   else begin
                       m_ir = m_mbr;
                       if (((m_ir >> 12) & 7) == 7) begin m_halt = 1; nph = 0; end
                       else nph = (m_ir & 16'h8000) ? 1 : 2;
                   end
                1: if (m_u == 0) m_mar = m_ir & 12'hFFF;
                   else if (m_u == 1) m_mbr = int'(mem[m_mar & 255]);
                   else begin m_ir = (m_ir & 16'hF000) | (m_mbr & 12'hFFF); nph = 2; end
                2: if (m_u == 0) m_mar = m_ir & 12'hFFF;
                   else if (m_u == 1) begin if (opc == 1) m_mbr = int'(mem[m_mar & 255]); end
                   else begin
                       if (opc == 1) m_acc = (m_acc + m_mbr) & 16'hFFFF;
                       if (irq_req && m_arm) begin nph = 3; m_arm = 0; end
                       else nph = 0;
                   end
                default: if (m_u == 0) m_mbr = m_pc;
                   else if (m_u == 1) begin m_mar = int'(SAVE); m_pc = int'(ISR); end
                   else nph = 0;
            endcase
            if (m_u == 2) begin m_u = 0; m_ph = nph; end
            else m_u = m_u + 1;
        end
    end

    initial begin
        int guard;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[0] = 16'h1080; // ADD 0x080
        mem[1] = 16'h9081; // ADD indirect via 0x081
        mem[2] = 16'h0000; // NOP
        mem[3] = 16'h2080; // unused opcode 010 acts as no-op
        mem[4] = 16'h1083; // ADD 0xFFFF (wraps)
        mem[5] = 16'h1084; // skipped by interrupt
        mem[8'hC0] = 16'h1085;
        mem[8'hC1] = 16'h7000; // HALT
        mem[8'h80] = 16'd5;
        mem[8'h81] = 16'h0082;
        mem[8'h82] = 16'd7;
        mem[8'h83] = 16'hFFFF;
        mem[8'h84] = 16'h1000;
        mem[8'h85] = 16'd100;
        model_reset();
        irq_req = 1'b1; // held high: ignored until armed (R9)
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 phase", int'(phase_o), 0);
        chk("R1 pc", int'(pc_o), 0);
        chk("R1 acc", int'(acc_o), 0);
        chk("R1 halted", int'(halted_o), 0);
        chk("R1 strobes", int'({mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        wait (pc_o == 12'd5);
        chk("R9 no save while disarmed", writes_seen, 0);
        chk("R6 acc before arming", int'(acc_o), 12);
        @(posedge clk); #1 irq_en_set = 1'b1;
        @(posedge clk); #1 irq_en_set = 1'b0;
        guard = 0;
        while (!halted_o && guard < 2000) begin @(posedge clk); guard++; end
        if (!halted_o) chk("watchdog R10", 0, 1);
        repeat (20) @(posedge clk);
        #1;
        chk("R8 saved pc", int'(mem[SAVE]), 5);
        chk("R8 single write", writes_seen, 1);
        chk("R6 final acc", int'(acc_o), 111);
        chk("R4 halt pc", int'(pc_o), 12'h0C2);
        chk("R4 halt phase", int'(phase_o), 0);
        chk("R7 instr at 5 skipped", int'(acc_o) & 16'h1000, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule